// File: doc/BRIEF.md
# Colour Palette Lookup with Indirect Register Port

This block holds a 256-entry colour palette and turns each incoming pixel index into red, green and blue bytes. A processor reaches it over a byte-wide bus with a 2-bit port select. One port is an address register shared by two kinds of access. A second port streams palette colour bytes. A third port reaches a small bank of control registers through the same address. The fourth port is reserved for overlay colours and does nothing.

To load colours, software writes a starting entry number to the address register. It then writes red, green and blue bytes for each entry. The address moves to the next entry after every blue byte, so a run of triples fills a run of entries. Colours are read back in the same red, green, blue order, and the address advances after each blue byte is read. Control registers are selected by writing their index to the address register. A control access never moves the address.

On the pixel side, the incoming index is ANDed with a read mask and then looked up. The colour appears on the outputs one clock later. If the palette-enable bit in the command register is clear, the outputs show black.

Top module: `clut_regif`

## Requirements
- R1: After a synchronous active-low reset, the address reads 0, the component pointer is at red, the read mask (index 4) reads 0xFF, the blink mask (index 5) reads 0x00, the command register (index 6) reads 0x40, the test register (index 7) reads 0x00, and the pixel outputs are 0.
- R2: Writes to port 1 (select value 1) take red, then green, then blue. The entry at the current address holds all three bytes once the blue byte has been written.
- R3: After each blue byte is written on port 1, the address increases by one, so consecutive triples fill consecutive entries.
- R4: An address increment from the last entry (255) wraps to entry 0.
- R5: Reading port 1 returns red, green, blue of the current entry in that order, and the address advances after the blue byte. Writing port 0 loads the address and returns the component pointer to red, even in the middle of a triple.
- R6: Port 2 (select value 2) writes and reads the control register whose index is held in the address register, for indices 4 to 7. It never changes the address. Other indices read 0 and ignore writes.
- R7: The pixel index is ANDed with the read mask before the lookup.
- R8: When bit 6 of the command register is 0, all three pixel outputs are 0.
- R9: A pixel index presented before a clock edge shows its colour on the outputs after that edge, and not before it.
- R10: Writes to port 3 (select value 3) change neither the address, the component pointer, nor any palette or control content, and reads of port 3 return 0.
- R11: Reading port 0 returns the current address. A read strobe given in the same cycle as a write strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Port select: 0 address, 1 palette, 2 control, 3 overlay |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port, combinational |
| pix_idx | input | 8 | Pixel index |
| pix_r | output | 8 | Red output, registered |
| pix_g | output | 8 | Green output, registered |
| pix_b | output | 8 | Blue output, registered |

## Verification
The bench builds the block with an 8-bit index and 8-bit colour components. These are the defaults, and they match the bus width. With these values the bench can step the address from entry 255 back to 0, and it can test a mask that clears the upper index bits so that a high pixel index lands on a low entry. The fixed control indices 4 to 7 also fall inside the address range, so the bench can read back every control register and check that a control access leaves the address unchanged.

// File: rtl/clut_pkg.sv
// Package: shared types and constants for the palette lookup block.
// Assumes the bus data width equals the colour component width.
package clut_pkg;
    typedef enum logic [1:0] {
        PORT_ADDR = 2'd0,
        PORT_PAL  = 2'd1,
        PORT_CTRL = 2'd2,
        PORT_OVL  = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        COMP_RED = 2'd0,
        COMP_GRN = 2'd1,
        COMP_BLU = 2'd2
    } comp_e;

    localparam int NUM_COMP     = 3;
    localparam int CTL_RMASK    = 4;
    localparam int CTL_BLINK    = 5;
    localparam int CTL_CMD      = 6;
    localparam int CTL_TEST     = 7;
    localparam int CMD_PAL_EN   = 6;
    localparam logic [7:0] CMD_RESET = 8'h40;
endpackage

// File: rtl/clut_seq.sv
// Module: address and component sequencer.
// Keeps the entry address and the red/green/blue pointer. A palette step
// advances the pointer and moves the address after blue. Loading the
// address sends the pointer back to red. Assumes at most one access per cycle.
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_addr,
    input  logic [IDX_W-1:0] load_val,
    input  logic             pal_step,
    output logic [IDX_W-1:0] addr,
    output comp_e            comp
);
    // Update the address and the component pointer on loads and palette steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            comp <= COMP_RED;
        end else if (load_addr) begin
            addr <= load_val;
            comp <= COMP_RED;
        end else if (pal_step) begin
            case (comp)
                COMP_RED: comp <= COMP_GRN;
                COMP_GRN: comp <= COMP_BLU;
                default: begin
                    comp <= COMP_RED;
                    addr <= addr + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/clut_ctrl.sv
// Module: indirect control register bank.
// Holds the read mask, blink mask, command and test registers at
// fixed indices. The index comes from the shared address register.
// Indices outside the bank read zero and ignore writes.
module clut_ctrl
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [COMP_W-1:0] wdata,
    output logic [COMP_W-1:0] rd_val,
    output logic [IDX_W-1:0]  rmask,
    output logic              pal_en
);
    logic [COMP_W-1:0] rmask_q, blink_q, cmd_q, test_q;

    // Write the selected control register. Reset gives all planes read, palette on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmask_q <= '1;
            blink_q <= '0;
            cmd_q   <= COMP_W'(CMD_RESET);
            test_q  <= '0;
        end else if (wr_en) begin
            case (int'(sel_idx))
                CTL_RMASK: rmask_q <= wdata;
                CTL_BLINK: blink_q <= wdata;
                CTL_CMD:   cmd_q   <= wdata;
                CTL_TEST:  test_q  <= wdata;
                default: ;
            endcase
        end
    end

    // Return the register chosen by the index.
    always_comb begin
        case (int'(sel_idx))
            CTL_RMASK: rd_val = rmask_q;
            CTL_BLINK: rd_val = blink_q;
            CTL_CMD:   rd_val = cmd_q;
            CTL_TEST:  rd_val = test_q;
            default:   rd_val = '0;
        endcase
    end

    assign rmask  = IDX_W'(rmask_q);
    assign pal_en = cmd_q[CMD_PAL_EN];
endmodule

// File: rtl/clut_mem.sv
// Module: palette storage with a bus port and a masked pixel lookup.
// One bank per colour component. All three banks are written together,
// and the bus side reads asynchronously. The lookup result is registered
// and is forced to zero when the palette is disabled.
module clut_mem
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [IDX_W-1:0]                   waddr,
    input  logic [NUM_COMP-1:0][COMP_W-1:0]    wcolor,
    input  logic [IDX_W-1:0]                   raddr,
    output logic [NUM_COMP-1:0][COMP_W-1:0]    rcolor,
    input  logic [IDX_W-1:0]                   pix_idx,
    input  logic [IDX_W-1:0]                   rmask,
    input  logic                               pal_en,
    output logic [NUM_COMP-1:0][COMP_W-1:0]    pix_q
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0] look_idx;
    assign look_idx = pix_idx & rmask;

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
        logic [COMP_W-1:0] bank [ENTRIES];

        // Store one component of a completed entry.
        always_ff @(posedge clk) begin
            if (we) bank[waddr] <= wcolor[c];
        end

        assign rcolor[c] = bank[raddr];

        // Register the looked-up component, or zero when the palette is off.
        always_ff @(posedge clk) begin
            if (!rst_n)      pix_q[c] <= '0;
            else if (pal_en) pix_q[c] <= bank[look_idx];
            else             pix_q[c] <= '0;
        end
    end
endmodule

// File: rtl/clut_regif.sv
// Module: top of the palette lookup block.
// Decodes the 2-bit port select, stages red and green until blue arrives,
// and steers bus reads. A read strobe in the same cycle as a write strobe
// is ignored. Assumes COMP_W is the bus width.
module clut_regif
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [COMP_W-1:0] bus_wdata,
    output logic [COMP_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [COMP_W-1:0] pix_r,
    output logic [COMP_W-1:0] pix_g,
    output logic [COMP_W-1:0] pix_b
);
    port_e                            port;
    logic                             rd_ok;
    logic                             wr_addr, wr_pal, wr_ctrl, rd_pal;
    logic [IDX_W-1:0]                 cur_addr;
    comp_e                            cur_comp;
    logic [COMP_W-1:0]                stage_r, stage_g;
    logic [NUM_COMP-1:0][COMP_W-1:0]  wcolor, rcolor, pix_q;
    logic [COMP_W-1:0]                ctl_val;
    logic [IDX_W-1:0]                 rmask;
    logic                             pal_en;
    logic                             commit;

    assign port    = port_e'(bus_sel);
    assign rd_ok   = bus_rd && !bus_wr;
    assign wr_addr = bus_wr && (port == PORT_ADDR);
    assign wr_pal  = bus_wr && (port == PORT_PAL);
    assign wr_ctrl = bus_wr && (port == PORT_CTRL);
    assign rd_pal  = rd_ok  && (port == PORT_PAL);
    assign commit  = wr_pal && (cur_comp == COMP_BLU);

    clut_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_addr (wr_addr),
        .load_val  (IDX_W'(bus_wdata)),
        .pal_step  (wr_pal || rd_pal),
        .addr      (cur_addr),
        .comp      (cur_comp)
    );

    clut_ctrl #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ctrl),
        .sel_idx (cur_addr),
        .wdata   (bus_wdata),
        .rd_val  (ctl_val),
        .rmask   (rmask),
        .pal_en  (pal_en)
    );

    // Hold red and green until the blue byte completes the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_r <= '0;
            stage_g <= '0;
        end else if (wr_pal) begin
            if (cur_comp == COMP_RED) stage_r <= bus_wdata;
            if (cur_comp == COMP_GRN) stage_g <= bus_wdata;
        end
    end

    assign wcolor[0] = stage_r;
    assign wcolor[1] = stage_g;
    assign wcolor[2] = bus_wdata;

    clut_mem #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (commit),
        .waddr   (cur_addr),
        .wcolor  (wcolor),
        .raddr   (cur_addr),
        .rcolor  (rcolor),
        .pix_idx (pix_idx),
        .rmask   (rmask),
        .pal_en  (pal_en),
        .pix_q   (pix_q)
    );

    // Steer read data from the selected port.
    always_comb begin
        case (port)
            PORT_ADDR: bus_rdata = COMP_W'(cur_addr);
            PORT_PAL: begin
                case (cur_comp)
                    COMP_RED: bus_rdata = rcolor[0];
                    COMP_GRN: bus_rdata = rcolor[1];
                    default:  bus_rdata = rcolor[2];
                endcase
            end
            PORT_CTRL: bus_rdata = ctl_val;
            default:   bus_rdata = '0;
        endcase
    end

    assign pix_r = pix_q[0];
    assign pix_g = pix_q[1];
    assign pix_b = pix_q[2];
endmodule

// File: rtl/clut_regif_chk.sv
// Module: assertion checker bound to the palette lookup top.
// Observes bus strobes, the sequencer state and the pixel outputs.
module clut_regif_chk #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_sel,
    input logic              bus_wr,
    input logic [COMP_W-1:0] bus_wdata,
    input logic [IDX_W-1:0]  cur_addr,
    input logic [1:0]        cur_comp,
    input logic              pal_en,
    input logic [COMP_W-1:0] pix_r,
    input logic [COMP_W-1:0] pix_g,
    input logic [COMP_W-1:0] pix_b
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cur_addr == '0 && cur_comp == 2'd0 && pix_r == '0 && pix_g == '0 && pix_b == '0));

    assert_blue_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd1 && cur_comp == 2'd2) |=> cur_addr == IDX_W'($past(cur_addr) + 1'b1));

    assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd0) |=> (cur_comp == 2'd0 && cur_addr == IDX_W'($past(bus_wdata))));

    assert_ctrl_no_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2) |=> ($stable(cur_addr) && $stable(cur_comp)));

    assert_blank_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pal_en |=> (pix_r == '0 && pix_g == '0 && pix_b == '0));

    assert_overlay_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd3) |=> ($stable(cur_addr) && $stable(cur_comp)));
endmodule

bind clut_regif clut_regif_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .cur_addr  (cur_addr),
    .cur_comp  (cur_comp),
    .pal_en    (pal_en),
    .pix_r     (pix_r),
    .pix_g     (pix_g),
    .pix_b     (pix_b)
);

// File: tb/clut_regif_tb.sv
module clut_regif_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0, rdata, pix = '0, pr, pg, pb;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    clut_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .pix_idx(pix),
        .pix_r(pr), .pix_g(pg), .pix_b(pb)
    );

    // Vector: {is_read, port, data}; data is the write value or the expected read.
    localparam logic [10:0] VEC [16] = '{
        {1'b0, 2'd0, 8'h10}, {1'b0, 2'd1, 8'hA1}, {1'b0, 2'd1, 8'hA2}, {1'b0, 2'd1, 8'hA3},
        {1'b0, 2'd1, 8'hB1}, {1'b0, 2'd1, 8'hB2}, {1'b0, 2'd1, 8'hB3}, {1'b1, 2'd0, 8'h12},
        {1'b0, 2'd0, 8'h10}, {1'b1, 2'd1, 8'hA1}, {1'b1, 2'd1, 8'hA2}, {1'b1, 2'd1, 8'hA3},
        {1'b1, 2'd1, 8'hB1}, {1'b1, 2'd1, 8'hB2}, {1'b1, 2'd1, 8'hB3}, {1'b1, 2'd0, 8'h12}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); sel = s; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] s, output logic [7:0] q);
        @(negedge clk); sel = s; rd = 1'b1;
        #1 q = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic look(input logic [7:0] idx);
        @(negedge clk); pix = idx;
        @(negedge clk); #1;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check("R1 pix_r", pr, 8'h00);
        check("R1 pix_g", pg, 8'h00);
        check("R1 pix_b", pb, 8'h00);
        bus_read(2'd0, q); check("R1 addr", q, 8'h00);
        bus_write(2'd0, 8'h04); bus_read(2'd2, q); check("R1 read mask", q, 8'hFF);
        bus_write(2'd0, 8'h05); bus_read(2'd2, q); check("R1 blink", q, 8'h00);
        bus_write(2'd0, 8'h06); bus_read(2'd2, q); check("R1 command", q, 8'h40);
        bus_write(2'd0, 8'h07); bus_read(2'd2, q); check("R1 test", q, 8'h00);

        // R2 R3 R5 R11: table of loads and readbacks
        for (int i = 0; i < 16; i++) begin
            if (VEC[i][10]) begin
                bus_read(VEC[i][9:8], q);
                check($sformatf("R2/R3/R5 vec %0d", i), q, VEC[i][7:0]);
            end else begin
                bus_write(VEC[i][9:8], VEC[i][7:0]);
            end
        end

        // R9 latency, then lookup values
        @(negedge clk); pix = 8'h10;
        @(negedge clk); #1;
        check("R9 first lookup r", pr, 8'hA1);
        check("R9 first lookup b", pb, 8'hA3);
        @(negedge clk); pix = 8'h11;
        #1 check("R9 before edge", pr, 8'hA1);
        @(negedge clk); #1;
        check("R9 after edge r", pr, 8'hB1);
        check("R9 after edge g", pg, 8'hB2);

        // R7 mask 0x1F maps 0xF0 to entry 0x10
        bus_write(2'd0, 8'h04); bus_write(2'd2, 8'h1F);
        look(8'hF0);
        check("R7 masked r", pr, 8'hA1);
        check("R7 masked g", pg, 8'hA2);
        bus_read(2'd0, q); check("R6 addr unchanged", q, 8'h04);
        bus_read(2'd2, q); check("R6 mask readback", q, 8'h1F);
        bus_write(2'd2, 8'hFF);

        // R8 command bit 6 cleared blanks outputs
        bus_write(2'd0, 8'h06); bus_write(2'd2, 8'h00);
        look(8'h10);
        check("R8 blank r", pr, 8'h00);
        check("R8 blank g", pg, 8'h00);
        check("R8 blank b", pb, 8'h00);
        bus_write(2'd2, 8'h40);
        look(8'h10);
        check("R8 restored r", pr, 8'hA1);

        // R6 index outside bank ignored
        bus_write(2'd0, 8'h09); bus_write(2'd2, 8'h77);
        bus_read(2'd2, q); check("R6 unused index", q, 8'h00);

        // R4 wrap from 255 to 0
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'hC1); bus_write(2'd1, 8'hC2); bus_write(2'd1, 8'hC3);
        bus_read(2'd0, q); check("R4 wrap addr", q, 8'h00);
        bus_write(2'd0, 8'hFF);
        bus_read(2'd1, q); check("R4 entry r", q, 8'hC1);
        bus_read(2'd1, q); bus_read(2'd1, q); check("R4 entry b", q, 8'hC3);
        bus_read(2'd0, q); check("R4 read wrap", q, 8'h00);

        // R5 address write mid-triple returns pointer to red
        bus_write(2'd0, 8'h20); bus_write(2'd1, 8'h11);
        bus_write(2'd0, 8'h20);
        bus_write(2'd1, 8'h22); bus_write(2'd1, 8'h33); bus_write(2'd1, 8'h44);
        bus_write(2'd0, 8'h20);
        bus_read(2'd1, q); check("R5 restart r", q, 8'h22);
        bus_read(2'd1, q); check("R5 restart g", q, 8'h33);

        // R10 overlay port inert
        bus_write(2'd3, 8'h55);
        bus_read(2'd1, q); check("R10 pointer kept", q, 8'h44);
        bus_read(2'd0, q); check("R10 addr kept", q, 8'h21);
        bus_read(2'd3, q); check("R10 overlay read", q, 8'h00);
        look(8'h20);
        check("R10 entry kept", pg, 8'h33);

        // R11 read with simultaneous write is ignored
        bus_write(2'd0, 8'h20);
        @(negedge clk); sel = 2'd1; rd = 1'b1; wr = 1'b1; wdata = 8'h66;
        @(negedge clk); rd = 1'b0; wr = 1'b0;
        bus_read(2'd1, q); check("R11 read suppressed", q, 8'h33);

        // R1 reset mid-run
        bus_write(2'd0, 8'h06); bus_write(2'd2, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 check("R1 rerst pix", pr, 8'h00);
        bus_read(2'd0, q); check("R1 rerst addr", q, 8'h00);
        bus_write(2'd0, 8'h06); bus_read(2'd2, q); check("R1 rerst command", q, 8'h40);

        done = 1'b1;
        summary();
    end
endmodule